// File: doc/BRIEF.md
# RTP Payload Channel Dispatcher

This block takes one descriptor for each received packet and decides which of sixteen channel structures should handle the payload. Each descriptor carries four things: the RTP marker bit, the 7-bit payload type, a flag that says whether an RTP header is present, and the UDP length. For packets that carry RTP, the lookup key is the marker plus the payload type. For packets that do not carry RTP, the key is the UDP length. The block walks a sixteen-entry match table one entry per clock. It returns the 4-bit number of the first entry that matches, together with that entry's channel class: PCM bearer, HDLC, CPU, or drop.

A register port loads the table one entry per write. Both the request side and the result side use valid/ready handshakes, and results come out in request order. Each table entry holds the following fields:

- a valid bit
- a key-kind bit (RTP key or length key)
- a marker value and a marker-ignore bit
- a payload type
- a UDP length
- a class code

Top module: `rtp_chan_dispatch`

## Requirements
- R1: An entry with cfgWrKeyIsLen=0 matches only a packet with reqHasRtp=1 whose payload type equals the entry's payload type and whose marker equals the entry's marker, unless the entry's marker-ignore bit is 1, in which case any marker matches.
- R2: An entry with cfgWrKeyIsLen=1 matches only a packet with reqHasRtp=0 whose UDP length equals the entry's length.
- R3: An entry whose valid bit is 0 never matches. RTP-key entries never match non-RTP packets, and length-key entries never match RTP packets.
- R4: When several entries match, the result is the lowest matching index.
- R5: When no entry matches, the result is entry 0, class code 3 (drop), with rspNoMatch=1.
- R6: On a match, rspEntry is the matching index, rspClass is that entry's class code (0 PCM, 1 HDLC, 2 CPU, 3 drop), and rspNoMatch=0.
- R7: For a match at index i, rspValid rises i+1 clock edges after the edge that accepts the request. For a miss, it rises after NUM_ENTRIES edges.
- R8: reqReady is high only while no request is in flight. rspValid holds, with rspEntry, rspClass and rspNoMatch unchanged, until the cycle it is taken with rspReady. Exactly one result is produced per accepted request.
- R9: cfgWrReady is low while a search runs. A write offered during a search is applied only after the search ends, so that search sees the old table and the next request sees the new one.
- R10: After reset, every table entry is invalid, reqReady=1, cfgWrReady=1 and rspValid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Descriptor offered |
| reqReady | output | 1 | Descriptor accepted when high with reqValid |
| reqMarker | input | 1 | RTP marker bit |
| reqPt | input | 7 | RTP payload type |
| reqHasRtp | input | 1 | Packet carries an RTP header |
| reqUdpLen | input | 16 | UDP length |
| cfgWrValid | input | 1 | Table write offered |
| cfgWrReady | output | 1 | Table write taken when high with cfgWrValid |
| cfgWrAddr | input | 4 | Entry index to write |
| cfgWrEntryValid | input | 1 | Entry valid bit |
| cfgWrKeyIsLen | input | 1 | 0: RTP key, 1: length key |
| cfgWrMarker | input | 1 | Marker value to match |
| cfgWrMarkerIgnore | input | 1 | Marker is don't-care |
| cfgWrPt | input | 7 | Payload type to match |
| cfgWrUdpLen | input | 16 | UDP length to match |
| cfgWrClass | input | 2 | Class code of the entry |
| rspValid | output | 1 | Result available |
| rspReady | input | 1 | Result consumed |
| rspEntry | output | 4 | Selected channel structure number |
| rspClass | output | 2 | Class code of the result |
| rspNoMatch | output | 1 | No entry matched |

## Verification
A stale or mis-stepped scan index shows up as the wrong entry number, or as a response edge at the wrong count after acceptance. The latency check therefore pins the index counter on every request, within at most sixteen cycles. A corrupted key register or a wrong compare rule turns a known hit into a miss, or into a shadowed higher entry, on the very next result. A control state that lets writes slip into a running search shows up at once as cfgWrReady high mid-search, or as a result taken from the new table one request too early.

// File: rtl/rtpd_pkg.sv
package rtpd_pkg;
  parameter int PT_W  = 7;
  parameter int LEN_W = 16;

  typedef enum logic [1:0] {
    CLS_PCM  = 2'd0,
    CLS_HDLC = 2'd1,
    CLS_CPU  = 2'd2,
    CLS_DROP = 2'd3
  } chanClass_t;

  typedef struct packed {
    logic             valid;
    logic             keyIsLen;
    logic             marker;
    logic             markerIgnore;
    logic [PT_W-1:0]  pt;
    logic [LEN_W-1:0] udpLen;
    chanClass_t       cls;
  } entry_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadKey;
    logic searchEn;
    logic capHit;
    logic capMiss;
  } strobe_t;
endpackage

// File: rtl/rtpd_ctrl.sv
module rtpd_ctrl
  import rtpd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    rspReady,
  input  logic    hit,
  input  logic    atLast,
  output logic    reqReady,
  output logic    rspValid,
  output logic    cfgWrReady,
  output strobe_t stb
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_RESP} state_t;
  state_t state, stateNext;

  always_comb begin
    stb        = '0;
    reqReady   = (state == ST_IDLE);
    rspValid   = (state == ST_RESP);
    cfgWrReady = (state != ST_SEARCH);
    stateNext  = state;
    unique case (state)
      ST_IDLE: begin
        stb.loadKey = reqValid;
        if (reqValid) stateNext = ST_SEARCH;
      end
      ST_SEARCH: begin
        stb.searchEn = 1'b1;
        stb.capHit   = hit;
        stb.capMiss  = !hit && atLast;
        if (hit || atLast) stateNext = ST_RESP;
      end
      ST_RESP: begin
        if (rspReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/rtpd_dpath.sv
module rtpd_dpath
  import rtpd_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             reqMarker,
  input  logic [PT_W-1:0]  reqPt,
  input  logic             reqHasRtp,
  input  logic [LEN_W-1:0] reqUdpLen,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgAddr,
  input  entry_t           cfgEntry,
  output logic             hit,
  output logic             atLast,
  output logic [IDX_W-1:0] rspEntry,
  output logic [1:0]       rspClass,
  output logic             rspNoMatch
);
  entry_t           tbl [NUM_ENTRIES];
  logic             kMarker, kHasRtp;
  logic [PT_W-1:0]  kPt;
  logic [LEN_W-1:0] kLen;
  logic [IDX_W-1:0] idx;
  entry_t           cur;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  tbl[g] <= '0;
      else if (cfgWe && cfgAddr == IDX_W'(g))     tbl[g] <= cfgEntry;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kMarker <= 1'b0;
      kHasRtp <= 1'b0;
      kPt     <= '0;
      kLen    <= '0;
    end else if (stb.loadKey) begin
      kMarker <= reqMarker;
      kHasRtp <= reqHasRtp;
      kPt     <= reqPt;
      kLen    <= reqUdpLen;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              idx <= '0;
    else if (stb.loadKey)                   idx <= '0;
    else if (stb.searchEn && !hit && !atLast) idx <= idx + 1'b1;
  end

  always_comb begin
    cur    = tbl[idx];
    atLast = (idx == IDX_W'(NUM_ENTRIES - 1));
    if (!cur.valid)        hit = 1'b0;
    else if (cur.keyIsLen) hit = !kHasRtp && (cur.udpLen == kLen);
    else                   hit = kHasRtp && (cur.pt == kPt) &&
                                 (cur.markerIgnore || cur.marker == kMarker);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspEntry   <= '0;
      rspClass   <= CLS_DROP;
      rspNoMatch <= 1'b0;
    end else if (stb.capHit) begin
      rspEntry   <= idx;
      rspClass   <= cur.cls;
      rspNoMatch <= 1'b0;
    end else if (stb.capMiss) begin
      rspEntry   <= '0;
      rspClass   <= CLS_DROP;
      rspNoMatch <= 1'b1;
    end
  end
endmodule

// File: rtl/rtp_chan_dispatch.sv
module rtp_chan_dispatch
  import rtpd_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqMarker,
  input  logic [PT_W-1:0]  reqPt,
  input  logic             reqHasRtp,
  input  logic [LEN_W-1:0] reqUdpLen,
  input  logic             cfgWrValid,
  output logic             cfgWrReady,
  input  logic [IDX_W-1:0] cfgWrAddr,
  input  logic             cfgWrEntryValid,
  input  logic             cfgWrKeyIsLen,
  input  logic             cfgWrMarker,
  input  logic             cfgWrMarkerIgnore,
  input  logic [PT_W-1:0]  cfgWrPt,
  input  logic [LEN_W-1:0] cfgWrUdpLen,
  input  logic [1:0]       cfgWrClass,
  output logic             rspValid,
  input  logic             rspReady,
  output logic [IDX_W-1:0] rspEntry,
  output logic [1:0]       rspClass,
  output logic             rspNoMatch
);
  strobe_t stb;
  logic    hit, atLast;
  entry_t  cfgEntry;

  always_comb begin
    cfgEntry.valid        = cfgWrEntryValid;
    cfgEntry.keyIsLen     = cfgWrKeyIsLen;
    cfgEntry.marker       = cfgWrMarker;
    cfgEntry.markerIgnore = cfgWrMarkerIgnore;
    cfgEntry.pt           = cfgWrPt;
    cfgEntry.udpLen       = cfgWrUdpLen;
    cfgEntry.cls          = chanClass_t'(cfgWrClass);
  end

  rtpd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rspReady(rspReady),
    .hit(hit), .atLast(atLast), .reqReady(reqReady), .rspValid(rspValid),
    .cfgWrReady(cfgWrReady), .stb(stb)
  );

  rtpd_dpath #(.NUM_ENTRIES(NUM_ENTRIES)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqMarker(reqMarker), .reqPt(reqPt), .reqHasRtp(reqHasRtp), .reqUdpLen(reqUdpLen),
    .cfgWe(cfgWrValid && cfgWrReady), .cfgAddr(cfgWrAddr), .cfgEntry(cfgEntry),
    .hit(hit), .atLast(atLast),
    .rspEntry(rspEntry), .rspClass(rspClass), .rspNoMatch(rspNoMatch)
  );
endmodule

// File: rtl/rtpd_checker.sv
module rtpd_checker #(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             cfgWrReady,
  input logic             rspValid,
  input logic             rspReady,
  input logic [IDX_W-1:0] rspEntry,
  input logic [1:0]       rspClass,
  input logic             rspNoMatch
);
  logic searching;
  int   waitCnt;
  assign searching = !reqReady && !rspValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     waitCnt <= 0;
    else if (reqValid && reqReady) waitCnt <= 0;
    else if (searching)            waitCnt <= waitCnt + 1;
  end

  p_req_rsp_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && rspValid));

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspEntry) &&
                                 $stable(rspClass) && $stable(rspNoMatch)));

  p_nomatch_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspNoMatch) |-> (rspClass == 2'd3 && rspEntry == '0));

  p_wr_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    searching |-> !cfgWrReady);

  p_latency_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= NUM_ENTRIES);
endmodule

bind rtp_chan_dispatch rtpd_checker #(.NUM_ENTRIES(NUM_ENTRIES)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .cfgWrReady(cfgWrReady), .rspValid(rspValid), .rspReady(rspReady),
  .rspEntry(rspEntry), .rspClass(rspClass), .rspNoMatch(rspNoMatch)
);

// File: tb/rtp_chan_dispatch_tb.sv
`timescale 1ns/1ps
module rtp_chan_dispatch_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqMarker = 0, reqHasRtp = 0;
  logic [6:0] reqPt = 0;
  logic [15:0] reqUdpLen = 0;
  logic cfgWrValid = 0, cfgWrEntryValid = 0, cfgWrKeyIsLen = 0, cfgWrMarker = 0, cfgWrMarkerIgnore = 0;
  logic [3:0] cfgWrAddr = 0;
  logic [6:0] cfgWrPt = 0;
  logic [15:0] cfgWrUdpLen = 0;
  logic [1:0] cfgWrClass = 0;
  logic rspReady = 0;
  logic reqReady, cfgWrReady, rspValid, rspNoMatch;
  logic [3:0] rspEntry;
  logic [1:0] rspClass;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtp_chan_dispatch dut_i (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeEntry(input int a, input bit v, input bit isLen, input bit m, input bit ign,
                            input int pt, input int len, input int cls);
    @(negedge clk);
    cfgWrValid = 1; cfgWrAddr = 4'(a); cfgWrEntryValid = v; cfgWrKeyIsLen = isLen;
    cfgWrMarker = m; cfgWrMarkerIgnore = ign; cfgWrPt = 7'(pt); cfgWrUdpLen = 16'(len);
    cfgWrClass = 2'(cls);
    while (!cfgWrReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cfgWrValid = 0;
  endtask

  // Sends one request, measures latency, holds rspReady low for two cycles (R8), then pops.
  task automatic lookup(input string req, input bit m, input int pt, input bit rtp, input int len,
                        input int expEntry, input int expCls, input bit expMiss, input int expLat);
    int lat = 0;
    logic [3:0] e0;
    @(negedge clk);
    chk(reqReady == 1, "R8", "reqReady idle", reqReady, 1);
    reqValid = 1; reqMarker = m; reqPt = 7'(pt); reqHasRtp = rtp; reqUdpLen = 16'(len);
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    while (!rspValid && lat < 40) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    chk(lat == expLat, "R7", {req, " latency"}, lat, expLat);
    chk(rspEntry == 4'(expEntry), req, "entry", rspEntry, expEntry);
    chk(rspClass == 2'(expCls), req, "class", rspClass, expCls);
    chk(rspNoMatch == expMiss, req, "noMatch", rspNoMatch, expMiss);
    e0 = rspEntry;
    repeat (2) @(negedge clk);
    chk(rspValid && rspEntry == e0 && !reqReady, "R8", "held result", rspEntry, e0);
    rspReady = 1;
    @(posedge clk);
    @(negedge clk);
    rspReady = 0;
    chk(!rspValid && reqReady, "R8", "single result", rspValid, 0);
  endtask

  task automatic testReset();
    chk(reqReady == 1 && cfgWrReady == 1, "R10", "ready after reset", reqReady, 1);
    chk(rspValid == 0, "R10", "rspValid after reset", rspValid, 0);
    lookup("R10", 0, 0, 1, 0, 0, 3, 1, 16);
    lookup("R10", 0, 0, 0, 0, 0, 3, 1, 16);
  endtask

  task automatic loadTable();
    writeEntry(0,  1, 0, 1, 0, 0,   0,   0); // RTP pt0 m1 PCM
    writeEntry(3,  1, 0, 0, 1, 96,  0,   1); // RTP pt96 any marker HDLC
    writeEntry(4,  1, 0, 0, 0, 96,  0,   2); // shadowed
    writeEntry(7,  1, 1, 0, 0, 0,   172, 2); // LEN 172 CPU
    writeEntry(8,  1, 1, 0, 0, 0,   172, 1); // shadowed
    writeEntry(9,  0, 0, 0, 0, 8,   0,   0); // invalid
    writeEntry(10, 1, 0, 0, 0, 8,   0,   3); // explicit drop
    writeEntry(12, 1, 1, 0, 0, 0,   40,  0); // LEN 40 PCM
    writeEntry(15, 1, 0, 1, 0, 127, 0,   1); // last index
  endtask

  task automatic testRtpKey();
    lookup("R1", 1, 0, 1, 0, 0, 0, 0, 1);
    lookup("R1", 0, 0, 1, 0, 0, 3, 1, 16);     // marker mismatch -> miss (R5)
    lookup("R4", 1, 96, 1, 0, 3, 1, 0, 4);
    lookup("R4", 0, 96, 1, 0, 3, 1, 0, 4);
    lookup("R6", 1, 127, 1, 0, 15, 1, 0, 16);
  endtask

  task automatic testLenKey();
    lookup("R2", 0, 0, 0, 172, 7, 2, 0, 8);
    lookup("R2", 0, 0, 0, 40, 12, 0, 0, 13);
    lookup("R5", 0, 0, 0, 41, 0, 3, 1, 16);
  endtask

  task automatic testKindAndValid();
    lookup("R3", 0, 5, 1, 172, 0, 3, 1, 16);   // RTP packet vs length entries
    lookup("R3", 1, 0, 0, 99, 0, 3, 1, 16);    // non-RTP packet vs RTP entry 0
    lookup("R3", 0, 8, 1, 0, 10, 3, 0, 11);    // invalid entry 9 skipped
  endtask

  task automatic testWriteHold();
    int lat = 0;
    @(negedge clk);
    reqValid = 1; reqMarker = 0; reqPt = 7'd96; reqHasRtp = 1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    cfgWrValid = 1; cfgWrAddr = 4'd1; cfgWrEntryValid = 1; cfgWrKeyIsLen = 0;
    cfgWrMarker = 0; cfgWrMarkerIgnore = 1; cfgWrPt = 7'd96; cfgWrClass = 2'd2;
    chk(cfgWrReady == 0, "R9", "write held in search", cfgWrReady, 0);
    while (!rspValid && lat < 40) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    chk(rspEntry == 4'd3, "R9", "old table used", rspEntry, 3);
    chk(cfgWrReady == 1, "R9", "write taken after search", cfgWrReady, 1);
    @(posedge clk);
    @(negedge clk);
    cfgWrValid = 0;
    rspReady = 1;
    @(posedge clk);
    @(negedge clk);
    rspReady = 0;
    lookup("R9", 0, 96, 1, 0, 1, 2, 0, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    loadTable();
    testRtpKey();
    testLenKey();
    testKindAndValid();
    testWriteHold();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule